// File: doc/BRIEF.md
# Message Time-Stamp Counter

This block keeps a 16-bit free-running time base for a serial message bus and stamps messages with it. A fixed divider turns the system clock into a one-microsecond enable. A second divider then sets how many microseconds one count step represents. A 3-bit configuration code picks that step, or it hands the counting over to an external tag clock, which is synchronised on entry and counted on its rising edges. The host can load any count value at any time, and it always sees the live count on a read port. When the count wraps from all-ones to zero, the block emits a one-cycle rollover event for the interrupt logic.

The message logic raises a start strobe or an end strobe for one cycle. The block then captures the count present in that cycle and offers it, tagged with the event kind, on a stack-write port. The port uses a valid/acknowledge handshake. A capture engine, built as a state machine, holds the offered word steady until it is acknowledged and can queue one further capture behind it.

The engine has three states. CAP_IDLE means nothing is offered. CAP_FULL means one word is offered. CAP_QUEUED means one word is offered and one more is waiting. The transitions are as follows. CAP_IDLE goes to CAP_FULL on any strobe. CAP_FULL goes to CAP_IDLE on an acknowledge with no strobe. CAP_FULL goes to CAP_QUEUED on a strobe with no acknowledge. CAP_FULL stays in CAP_FULL when an acknowledge and a strobe come together, and the new word replaces the offered one. CAP_QUEUED goes to CAP_FULL on an acknowledge with no strobe, and the waiting word moves out to the port. CAP_QUEUED stays in CAP_QUEUED on an acknowledge together with a strobe, and also on a strobe alone. In the strobe-alone case the new capture is discarded.

Top module: `ttag_counter`

## Requirements
- R1: After reset the count is 0, stk_valid is 0, rollover is 0 and the configuration code is 0.
- R2: With configuration code c in 0..5, the count steps by one every CLK_PER_US·2^(c+1) clock cycles. k clock edges after a load of value W (with no later write), the count reads W + floor(k / (CLK_PER_US·2^(c+1))).
- R3: Codes 6 and 7 select the external tag clock. The count then rises by exactly one for each rising edge of ext_tclk, after a two-flop synchroniser, and the internal divider has no effect on the count.
- R4: A host load sets count_o to host_wdata at the next edge and restarts the divider phase. A load wins over a step in the same cycle. count_o always shows the current count.
- R5: A configuration write takes cfg_sel, leaves the count unchanged, suppresses any step in its own cycle and restarts the divider phase.
- R6: rollover is high for exactly one cycle, the cycle right after a step takes the count from 16'hFFFF to 0. A host load never raises it.
- R7: A start or end strobe captures the count present in the strobe cycle. When the port is empty, that word appears on stk_data at the next edge with stk_valid high. stk_is_eom is 1 for an end event and 0 for a start event.
- R8: While stk_valid is high and stk_ack is low, stk_data and stk_is_eom stay stable and stk_valid stays high.
- R9: One extra capture queues behind the offered word and is offered, in order, after the acknowledge. An acknowledge and a strobe in the same cycle offer or queue the new word with no loss.
- R10: A strobe while both the offered and queued words are held is discarded. When start and end strobes come in the same cycle, only the start capture is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_load | input | 1 | Load the count from host_wdata |
| host_wdata | input | 16 | Value loaded into the count |
| count_o | output | 16 | Live count, the host read value |
| cfg_wr | input | 1 | Write the resolution code |
| cfg_sel | input | 3 | 0..5 select 2..64 us per step; 6, 7 select the external clock |
| ext_tclk | input | 1 | External tag clock, asynchronous |
| som | input | 1 | Start-of-message strobe |
| eom | input | 1 | End-of-message strobe |
| stk_valid | output | 1 | Stack-write word offered |
| stk_data | output | 16 | Captured count |
| stk_is_eom | output | 1 | 1 for an end-of-message capture, 0 for a start capture |
| stk_ack | input | 1 | Stack-write word accepted this cycle |
| rollover | output | 1 | One-cycle wrap event |

## Verification
The bench sweeps all six internal resolutions. It samples on both sides of each step boundary, so an off-by-one divider shows up as a count that changes one cycle early or late. It places a host load and a configuration write exactly on a step edge: a design in which the step won would read one higher. It also strobes a capture in that same edge cycle, where a design that captured after the increment would stamp one too many. It fills the capture queue and overflows it, and it fires strobes alongside acknowledges and alongside each other. A design that lost or reordered words would then offer a value or event kind other than the expected one. In external mode it checks that a long quiet stretch leaves the count alone.

// File: rtl/ttag_pkg.sv
package ttag_pkg;
    typedef enum logic [1:0] {
        CAP_IDLE   = 2'd0,
        CAP_FULL   = 2'd1,
        CAP_QUEUED = 2'd2
    } cap_state_e;

    localparam int SEL_W = 3;

    function automatic logic sel_is_ext(input logic [SEL_W-1:0] sel);
        return sel[2] & sel[1];
    endfunction
endpackage

// File: rtl/ttag_prescaler.sv
module ttag_prescaler #(
    parameter int CLK_PER_US  = 50,
    parameter int MAX_RES_LOG = 6
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       restart,
    input  logic [2:0] sel,
    output logic       tick
);
    localparam int US_W  = (CLK_PER_US > 1) ? $clog2(CLK_PER_US) : 1;
    localparam int RES_W = MAX_RES_LOG;

    logic [US_W-1:0]  us_cnt;
    logic [RES_W-1:0] res_cnt;
    logic [RES_W-1:0] res_last;
    logic [RES_W:0]   span;
    logic             us_pulse;

    always_comb begin
        span     = (RES_W+1)'(2) << sel;
        res_last = span[RES_W-1:0] - RES_W'(1);
        us_pulse = (us_cnt == US_W'(CLK_PER_US - 1));
        tick     = us_pulse && (res_cnt == res_last) && !restart;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            us_cnt  <= '0;
            res_cnt <= '0;
        end else if (restart) begin
            us_cnt  <= '0;
            res_cnt <= '0;
        end else if (us_pulse) begin
            us_cnt  <= '0;
            res_cnt <= (res_cnt == res_last) ? '0 : res_cnt + RES_W'(1);
        end else begin
            us_cnt  <= us_cnt + US_W'(1);
        end
    end
endmodule

// File: rtl/ttag_extsync.sv
module ttag_extsync (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise
);
    logic meta_q, sync_q, prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= 1'b0;
            sync_q <= 1'b0;
            prev_q <= 1'b0;
        end else begin
            meta_q <= async_in;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    assign rise = sync_q & ~prev_q;
endmodule

// File: rtl/ttag_capture.sv
module ttag_capture
    import ttag_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             som,
    input  logic             eom,
    input  logic             ack,
    input  logic [CNT_W-1:0] count,
    output logic             valid,
    output logic [CNT_W-1:0] data,
    output logic             is_eom
);
    cap_state_e       state, state_nx;
    logic             evt, evt_kind;
    logic [CNT_W-1:0] pend_data;
    logic             pend_eom;

    assign evt      = som | eom;
    assign evt_kind = eom & ~som;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= CAP_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            CAP_IDLE:   if (evt) state_nx = CAP_FULL;
            CAP_FULL:   if (ack && !evt) state_nx = CAP_IDLE;
                        else if (!ack && evt) state_nx = CAP_QUEUED;
            CAP_QUEUED: if (ack && !evt) state_nx = CAP_FULL;
            default:    state_nx = CAP_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data      <= '0;
            is_eom    <= 1'b0;
            pend_data <= '0;
            pend_eom  <= 1'b0;
        end else begin
            unique case (state)
                CAP_IDLE: if (evt) begin
                    data   <= count;
                    is_eom <= evt_kind;
                end
                CAP_FULL: if (evt) begin
                    if (ack) begin
                        data   <= count;
                        is_eom <= evt_kind;
                    end else begin
                        pend_data <= count;
                        pend_eom  <= evt_kind;
                    end
                end
                CAP_QUEUED: if (ack) begin
                    data   <= pend_data;
                    is_eom <= pend_eom;
                    if (evt) begin
                        pend_data <= count;
                        pend_eom  <= evt_kind;
                    end
                end
                default: ;
            endcase
        end
    end

    assign valid = (state != CAP_IDLE);
endmodule

// File: rtl/ttag_counter.sv
module ttag_counter
    import ttag_pkg::*;
#(
    parameter int CLK_PER_US  = 50,
    parameter int CNT_W       = 16,
    parameter int MAX_RES_LOG = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             host_load,
    input  logic [CNT_W-1:0] host_wdata,
    output logic [CNT_W-1:0] count_o,
    input  logic             cfg_wr,
    input  logic [SEL_W-1:0] cfg_sel,
    input  logic             ext_tclk,
    input  logic             som,
    input  logic             eom,
    output logic             stk_valid,
    output logic [CNT_W-1:0] stk_data,
    output logic             stk_is_eom,
    input  logic             stk_ack,
    output logic             rollover
);
    logic [SEL_W-1:0] sel_q;
    logic [CNT_W-1:0] cnt_q;
    logic             int_tick, ext_rise, step, restart;

    assign restart = host_load | cfg_wr;

    ttag_prescaler #(
        .CLK_PER_US (CLK_PER_US),
        .MAX_RES_LOG(MAX_RES_LOG)
    ) pre_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .restart(restart),
        .sel    (sel_q),
        .tick   (int_tick)
    );

    ttag_extsync ext_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_in(ext_tclk),
        .rise    (ext_rise)
    );

    assign step = !restart && (sel_is_ext(sel_q) ? ext_rise : int_tick);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q    <= '0;
            cnt_q    <= '0;
            rollover <= 1'b0;
        end else begin
            if (cfg_wr) sel_q <= cfg_sel;
            rollover <= step && (cnt_q == {CNT_W{1'b1}});
            if (host_load) cnt_q <= host_wdata;
            else if (step) cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    assign count_o = cnt_q;

    ttag_capture #(.CNT_W(CNT_W)) cap_i (
        .clk   (clk),
        .rst_n (rst_n),
        .som   (som),
        .eom   (eom),
        .ack   (stk_ack),
        .count (cnt_q),
        .valid (stk_valid),
        .data  (stk_data),
        .is_eom(stk_is_eom)
    );
endmodule

// File: rtl/ttag_counter_chk.sv
module ttag_counter_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             host_load,
    input logic [CNT_W-1:0] host_wdata,
    input logic [CNT_W-1:0] count_o,
    input logic             cfg_wr,
    input logic             som,
    input logic             eom,
    input logic             stk_valid,
    input logic [CNT_W-1:0] stk_data,
    input logic             stk_is_eom,
    input logic             stk_ack,
    input logic             rollover
);
    // R2, R3: without a load the count holds or moves up by one
    a_r2_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        !host_load |=> (count_o == $past(count_o)) || (count_o == $past(count_o) + CNT_W'(1)));

    a_r4_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
        host_load |=> count_o == $past(host_wdata));

    a_r5_cfg_holds: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr && !host_load |=> count_o == $past(count_o));

    a_r6_wrap_only: assert property (@(posedge clk) disable iff (!rst_n)
        rollover |-> (count_o == '0) && ($past(count_o) == {CNT_W{1'b1}}) && !$past(host_load));

    a_r7_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (som || eom) && !stk_valid |=> stk_valid && (stk_data == $past(count_o))
            && (stk_is_eom == $past(!som)));

    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        stk_valid && !stk_ack |=> stk_valid && $stable(stk_data) && $stable(stk_is_eom));
endmodule

bind ttag_counter ttag_counter_chk #(.CNT_W(CNT_W)) chk_i (.*);

// File: tb/ttag_counter_tb_top.sv
module ttag_counter_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int CPU        = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_load = 1'b0;
    logic [15:0] host_wdata = '0;
    logic [15:0] count_o;
    logic        cfg_wr = 1'b0;
    logic [2:0]  cfg_sel = '0;
    logic        ext_tclk = 1'b0;
    logic        som = 1'b0, eom = 1'b0, stk_ack = 1'b0;
    logic        stk_valid, stk_is_eom, rollover;
    logic [15:0] stk_data;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ttag_counter #(.CLK_PER_US(CPU)) dut_i (
        .clk(clk), .rst_n(rst_n), .host_load(host_load), .host_wdata(host_wdata),
        .count_o(count_o), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel), .ext_tclk(ext_tclk),
        .som(som), .eom(eom), .stk_valid(stk_valid), .stk_data(stk_data),
        .stk_is_eom(stk_is_eom), .stk_ack(stk_ack), .rollover(rollover)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic adv(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic load(input logic [15:0] w);
        host_load = 1'b1; host_wdata = w;
        @(negedge clk);
        host_load = 1'b0;
    endtask

    task automatic cfg(input logic [2:0] c);
        cfg_wr = 1'b1; cfg_sel = c;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic strobe(input logic s, input logic e, input logic a);
        som = s; eom = e; stk_ack = a;
        @(negedge clk);
        som = 1'b0; eom = 1'b0; stk_ack = 1'b0;
    endtask

    task automatic expect_port(input string req, input logic v, input logic [15:0] d, input logic k);
        check({req, " valid"}, 32'(stk_valid), 32'(v));
        if (v) begin
            check({req, " data"}, 32'(stk_data), 32'(d));
            check({req, " kind"}, 32'(stk_is_eom), 32'(k));
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++; n_checks++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        adv(3);
        rst_n = 1'b1;
        // R1 reset state
        check("R1 count", 32'(count_o), 0);
        check("R1 valid", 32'(stk_valid), 0);
        check("R1 rollover", 32'(rollover), 0);

        // R2 sweep of every internal resolution around step boundaries
        for (int c = 0; c < 6; c++) begin
            int per;
            int k;
            int pts[5];
            per = CPU * (2 << c);
            pts = '{per - 1, per, 2*per - 1, 2*per, 3*per + 1};
            cfg(3'(c));
            load(16'(100 + 7*c));
            k = 0;
            for (int p = 0; p < 5; p++) begin
                adv(pts[p] - k);
                k = pts[p];
                check("R2 rate", 32'(count_o), 32'(100 + 7*c + k / per));
            end
        end

        // R4 load on a step edge wins
        cfg(0);
        load(16'd300);
        adv(3);
        load(16'd500);
        check("R4 load wins", 32'(count_o), 500);
        adv(3);
        check("R4 phase restart", 32'(count_o), 500);
        adv(1);
        check("R4 next step", 32'(count_o), 501);

        // R5 configuration write on a step edge
        load(16'd900);
        adv(3);
        cfg(0);
        check("R5 cfg suppress", 32'(count_o), 900);
        adv(3);
        check("R5 phase restart", 32'(count_o), 900);
        adv(1);
        check("R5 next step", 32'(count_o), 901);

        // R6 rollover
        load(16'hFFFF);
        adv(3);
        check("R6 pre-wrap", 32'(count_o), 32'hFFFF);
        check("R6 no early pulse", 32'(rollover), 0);
        adv(1);
        check("R6 wrapped", 32'(count_o), 0);
        check("R6 pulse", 32'(rollover), 1);
        adv(1);
        check("R6 one cycle", 32'(rollover), 0);
        load(16'hFFFF);
        adv(3);
        load(16'h0000);
        check("R6 load no pulse", 32'(rollover), 0);
        check("R4 load value", 32'(count_o), 0);

        // R3 external clock
        cfg(6);
        load(16'd50);
        for (int i = 0; i < 5; i++) begin
            ext_tclk = 1'b1; adv(3);
            ext_tclk = 1'b0; adv(3);
        end
        adv(4);
        check("R3 ext edges", 32'(count_o), 55);
        adv(300);
        check("R3 internal ignored", 32'(count_o), 55);
        cfg(7);
        ext_tclk = 1'b1; adv(3);
        ext_tclk = 1'b0; adv(4);
        check("R3 code 7", 32'(count_o), 56);

        // R7 capture on the step edge takes the pre-step value
        cfg(0);
        load(16'd700);
        adv(3);
        strobe(1, 0, 0);
        check("R7 count stepped", 32'(count_o), 701);
        expect_port("R7 edge capture", 1, 16'd700, 0);
        strobe(0, 0, 1);
        expect_port("R7 drained", 0, 0, 0);

        // R7..R10 capture queue with the slowest resolution
        cfg(5);
        load(16'h1111);
        strobe(1, 0, 0);
        expect_port("R7 som capture", 1, 16'h1111, 0);
        adv(3);
        expect_port("R8 held", 1, 16'h1111, 0);
        load(16'h2222);
        strobe(0, 1, 0);
        expect_port("R8 held while queued", 1, 16'h1111, 0);
        load(16'h3333);
        strobe(1, 0, 0);
        strobe(0, 0, 1);
        expect_port("R9 queued offered", 1, 16'h2222, 1);
        strobe(0, 0, 1);
        expect_port("R10 overflow dropped", 0, 0, 0);

        strobe(1, 1, 0);
        expect_port("R10 som wins", 1, 16'h3333, 0);
        strobe(0, 0, 1);
        expect_port("R10 eom dropped", 0, 0, 0);

        load(16'h4444);
        strobe(1, 0, 0);
        load(16'h5555);
        strobe(0, 1, 1);
        expect_port("R9 ack with strobe", 1, 16'h5555, 1);
        strobe(0, 0, 1);
        expect_port("R9 empty", 0, 0, 0);

        load(16'h6666);
        strobe(1, 0, 0);
        strobe(0, 1, 0);
        load(16'h7777);
        strobe(1, 0, 1);
        expect_port("R9 queued ack+strobe", 1, 16'h6666, 1);
        strobe(0, 0, 1);
        expect_port("R9 order", 1, 16'h7777, 0);
        strobe(0, 0, 1);
        expect_port("R9 final empty", 0, 0, 0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule